// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a single-stage arithmetic and logic unit for 32-bit words. One datapath handles three views of a word: the whole word, two 16-bit halves, or four 8-bit bytes. Full-word add and subtract come in three forms: plain wrap-around, signed saturating, and unsigned saturating. In the split views it adds lanes and compares lanes, and no lane affects the one next to it. Bitwise logic operations and a per-half arithmetic right shift complete the set. The shift keeps each half's own sign bit.

Every cycle the block can take one new pair of operands with an operation code. The result appears on a registered output one cycle later, together with a registered valid strobe. When no operation is issued, the result register keeps its last value. A lane compare writes a mask: all ones in each lane where the test holds, all zeros where it does not. The mask can then select or blend data in later logic.

Top module: `simd_alu`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` in each cycle equals `in_valid` of the previous cycle. An operation issued in every cycle produces its own result one cycle after it is issued, with no gaps.
- R3: Opcode 0 returns `op_a + op_b` modulo 2^32. Opcode 1 returns `op_a - op_b` modulo 2^32.
- R4: Opcode 2 (signed add) and opcode 3 (signed subtract) treat the operands as two's complement. A positive overflow gives 0x7FFFFFFF, a negative overflow gives 0x80000000, and any other case gives the exact result.
- R5: Opcode 4 (unsigned add) gives 0xFFFFFFFF when the sum exceeds 32 bits. Opcode 5 (unsigned subtract) gives 0 when `op_b` is greater than `op_a`. Otherwise both give the exact result.
- R6: Opcode 6 adds the two 16-bit halves independently, and opcode 7 adds the four bytes independently. Each lane wraps within itself and carries nothing into the lane above.
- R7: Lane compares write 0xFFFF per half or 0xFF per byte where the test holds, and 0 where it does not. The opcodes are: 8 = halves equal, 9 = halves signed greater (`op_a` > `op_b`), 10 = halves unsigned greater, 11 = bytes equal, 12 = bytes signed greater, 13 = bytes unsigned greater.
- R8: Opcode 14 gives `op_a & op_b`, opcode 15 gives `op_a | op_b`, opcode 16 gives `op_a ^ op_b`, and opcode 17 gives `~op_a`.
- R9: Opcode 18 shifts each 16-bit half of `op_a` right by `shamt` (0..15), filling with that half's own bit 15.
- R10: Opcodes 19 to 31 give a result of 0.
- R11: While `in_valid` is 0, `result` keeps its value and the operand and opcode inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the current operands |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 5 | Operation select (see requirements) |
| shamt | input | 4 | Shift amount for the per-half shift |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 32 | Registered result |

## Verification
The bench builds the block with its default 32-bit word, so the 16-bit and 8-bit lanes are the ones the requirements name. It uses operand values that put the saturation limits, lane carry-outs and the shift extremes (0 and 15) at exact boundaries. The sign-bit patterns 0x80 and 0x8000 separate the signed lane compares from the unsigned ones. At this width every constant in the requirements can be checked directly against fixed expected words.

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int DW = 32,
  parameter int OPW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [DW-1:0]              op_a,
  input  logic [DW-1:0]              op_b,
  input  logic [OPW-1:0]             opcode,
  input  logic [$clog2(DW/2)-1:0]    shamt,
  output logic                       out_valid,
  output logic [DW-1:0]              result
);
  localparam int H   = DW / 2;
  localparam int Q   = DW / 4;
  localparam int NH  = 2;
  localparam int NQ  = 4;

  localparam logic [OPW-1:0] OP_ADD    = 5'd0;
  localparam logic [OPW-1:0] OP_SUB    = 5'd1;
  localparam logic [OPW-1:0] OP_ADDS   = 5'd2;
  localparam logic [OPW-1:0] OP_SUBS   = 5'd3;
  localparam logic [OPW-1:0] OP_ADDUS  = 5'd4;
  localparam logic [OPW-1:0] OP_SUBUS  = 5'd5;
  localparam logic [OPW-1:0] OP_ADDH   = 5'd6;
  localparam logic [OPW-1:0] OP_ADDB   = 5'd7;
  localparam logic [OPW-1:0] OP_EQH    = 5'd8;
  localparam logic [OPW-1:0] OP_GTH    = 5'd9;
  localparam logic [OPW-1:0] OP_GTUH   = 5'd10;
  localparam logic [OPW-1:0] OP_EQB    = 5'd11;
  localparam logic [OPW-1:0] OP_GTB    = 5'd12;
  localparam logic [OPW-1:0] OP_GTUB   = 5'd13;
  localparam logic [OPW-1:0] OP_AND    = 5'd14;
  localparam logic [OPW-1:0] OP_OR     = 5'd15;
  localparam logic [OPW-1:0] OP_XOR    = 5'd16;
  localparam logic [OPW-1:0] OP_NOT    = 5'd17;
  localparam logic [OPW-1:0] OP_SHRH   = 5'd18;

  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0]   sum_x, dif_x;
  logic          sovf_add, sovf_sub;
  logic [DW-1:0] sat_sadd, sat_ssub, sat_uadd, sat_usub;
  logic [DW-1:0] add_h, add_b, eq_h, gt_h, gtu_h, eq_b, gt_b, gtu_b, shr_h;
  logic [DW-1:0] nxt;

  assign sum_x = {1'b0, op_a} + {1'b0, op_b};
  assign dif_x = {1'b0, op_a} - {1'b0, op_b};

  assign sovf_add = (op_a[DW-1] == op_b[DW-1]) && (sum_x[DW-1] != op_a[DW-1]);
  assign sovf_sub = (op_a[DW-1] != op_b[DW-1]) && (dif_x[DW-1] != op_a[DW-1]);

  assign sat_sadd = sovf_add ? (op_a[DW-1] ? SMIN : SMAX) : sum_x[DW-1:0];
  assign sat_ssub = sovf_sub ? (op_a[DW-1] ? SMIN : SMAX) : dif_x[DW-1:0];
  assign sat_uadd = sum_x[DW] ? {DW{1'b1}} : sum_x[DW-1:0];
  assign sat_usub = dif_x[DW] ? {DW{1'b0}} : dif_x[DW-1:0];

  for (genvar i = 0; i < NH; i++) begin : g_half
    logic [H-1:0] a_h, b_h;
    assign a_h = op_a[i*H +: H];
    assign b_h = op_b[i*H +: H];
    assign add_h[i*H +: H] = a_h + b_h;
    assign eq_h [i*H +: H] = {H{a_h == b_h}};
    assign gt_h [i*H +: H] = {H{$signed(a_h) > $signed(b_h)}};
    assign gtu_h[i*H +: H] = {H{a_h > b_h}};
    assign shr_h[i*H +: H] = $signed(a_h) >>> shamt;
  end

  for (genvar j = 0; j < NQ; j++) begin : g_byte
    logic [Q-1:0] a_q, b_q;
    assign a_q = op_a[j*Q +: Q];
    assign b_q = op_b[j*Q +: Q];
    assign add_b[j*Q +: Q] = a_q + b_q;
    assign eq_b [j*Q +: Q] = {Q{a_q == b_q}};
    assign gt_b [j*Q +: Q] = {Q{$signed(a_q) > $signed(b_q)}};
    assign gtu_b[j*Q +: Q] = {Q{a_q > b_q}};
  end

  always_comb begin
    case (opcode)
      OP_ADD:   nxt = sum_x[DW-1:0];
      OP_SUB:   nxt = dif_x[DW-1:0];
      OP_ADDS:  nxt = sat_sadd;
      OP_SUBS:  nxt = sat_ssub;
      OP_ADDUS: nxt = sat_uadd;
      OP_SUBUS: nxt = sat_usub;
      OP_ADDH:  nxt = add_h;
      OP_ADDB:  nxt = add_b;
      OP_EQH:   nxt = eq_h;
      OP_GTH:   nxt = gt_h;
      OP_GTUH:  nxt = gtu_h;
      OP_EQB:   nxt = eq_b;
      OP_GTB:   nxt = gt_b;
      OP_GTUB:  nxt = gtu_b;
      OP_AND:   nxt = op_a & op_b;
      OP_OR:    nxt = op_a | op_b;
      OP_XOR:   nxt = op_a ^ op_b;
      OP_NOT:   nxt = ~op_a;
      OP_SHRH:  nxt = shr_h;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DW = 32,
  parameter int OPW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [DW-1:0]  op_a,
  input logic [DW-1:0]  op_b,
  input logic [OPW-1:0] opcode,
  input logic           out_valid,
  input logic [DW-1:0]  result
);
  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R4
  pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 5'd2 && !op_a[DW-1] && !op_b[DW-1]) |=> !result[DW-1]);

  // R5
  unsigned_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 5'd4) |=> (result >= $past(op_a)));

  // R7
  half_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 5'd8 && opcode <= 5'd10) |=>
      ((result[DW/2-1:0] == '0) || (result[DW/2-1:0] == {(DW/2){1'b1}})));

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 5'd19) |=> (result == '0));
endmodule

bind simd_alu simd_alu_chk #(.DW(DW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .opcode(opcode), .out_valid(out_valid), .result(result)
);

// File: tb/tb_simd_alu.sv
module tb_simd_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [4:0]  opcode = '0;
  logic [3:0]  shamt = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .shamt(shamt), .out_valid(out_valid), .result(result)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [4:0] op, logic [31:0] a, logic [31:0] b,
                       logic [3:0] sh, string tag, logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; op_a = a; op_b = b; shamt = sh;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, result, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
  endtask

  task automatic t_wrap();
    issue(5'd0, 32'hFFFF_FFFF, 32'h1, 4'd0, "R3 add wrap", 32'h0);
    issue(5'd1, 32'h0, 32'h1, 4'd0, "R3 sub wrap", 32'hFFFF_FFFF);
  endtask

  task automatic t_ssat();
    issue(5'd2, 32'h7FFF_FFFF, 32'h1, 4'd0, "R4 sadd pos", 32'h7FFF_FFFF);
    issue(5'd3, 32'h8000_0000, 32'h1, 4'd0, "R4 ssub neg", 32'h8000_0000);
    issue(5'd2, 32'h5, 32'hFFFF_FFFD, 4'd0, "R4 sadd exact", 32'h2);
  endtask

  task automatic t_usat();
    issue(5'd4, 32'hFFFF_FFF0, 32'h20, 4'd0, "R5 uadd clamp", 32'hFFFF_FFFF);
    issue(5'd5, 32'd10, 32'd20, 4'd0, "R5 usub floor", 32'h0);
    issue(5'd5, 32'd20, 32'd10, 4'd0, "R5 usub exact", 32'd10);
  endtask

  task automatic t_lane_add();
    issue(5'd6, 32'h0001_FFFF, 32'h0001_0001, 4'd0, "R6 half add", 32'h0002_0000);
    issue(5'd7, 32'h01FF_80FF, 32'h0101_0101, 4'd0, "R6 byte add", 32'h0200_8100);
  endtask

  task automatic t_cmp();
    issue(5'd8,  32'h1234_5678, 32'h1234_0000, 4'd0, "R7 eq half", 32'hFFFF_0000);
    issue(5'd9,  32'h8000_0001, 32'h0001_0000, 4'd0, "R7 gt half", 32'h0000_FFFF);
    issue(5'd10, 32'h8000_0001, 32'h0001_0000, 4'd0, "R7 gtu half", 32'hFFFF_FFFF);
    issue(5'd11, 32'h1122_3344, 32'h1100_3300, 4'd0, "R7 eq byte", 32'hFF00_FF00);
    issue(5'd12, 32'h8001_7F00, 32'h7F00_8001, 4'd0, "R7 gt byte", 32'h00FF_FF00);
    issue(5'd13, 32'h8001_7F00, 32'h7F00_8001, 4'd0, "R7 gtu byte", 32'hFFFF_0000);
  endtask

  task automatic t_logic();
    issue(5'd14, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'd0, "R8 and", 32'hF000_F000);
    issue(5'd15, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'd0, "R8 or",  32'hFFF0_FFF0);
    issue(5'd16, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'd0, "R8 xor", 32'h0FF0_0FF0);
    issue(5'd17, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'd0, "R8 not", 32'h0F0F_0F0F);
  endtask

  task automatic t_shift();
    issue(5'd18, 32'h8000_7FFF, 32'h0, 4'd4,  "R9 shr 4",  32'hF800_07FF);
    issue(5'd18, 32'h8000_4000, 32'h0, 4'd15, "R9 shr 15", 32'hFFFF_0000);
    issue(5'd18, 32'h1234_ABCD, 32'h0, 4'd0,  "R9 shr 0",  32'h1234_ABCD);
  endtask

  task automatic t_undef();
    issue(5'd19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd3, "R10 op19", 32'h0);
    issue(5'd31, 32'h1234_5678, 32'h0, 4'd0, "R10 op31", 32'h0);
  endtask

  task automatic t_stream();
    @(negedge clk);
    in_valid = 1'b1; opcode = 5'd0; op_a = 32'd1; op_b = 32'd2;
    @(negedge clk);
    check("R2 b2b 1", result, 32'd3);
    opcode = 5'd14; op_a = 32'hFF; op_b = 32'h0F;
    @(negedge clk);
    check("R2 b2b 2", result, 32'h0F);
    opcode = 5'd1; op_a = 32'd9; op_b = 32'd4;
    @(negedge clk);
    check("R2 b2b 3", result, 32'd5);
    check("R2 b2b valid", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_hold();
    issue(5'd15, 32'hA000_0000, 32'h0000_000A, 4'd0, "R11 setup", 32'hA000_000A);
    opcode = 5'd17; op_a = 32'h0; op_b = 32'h1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      op_a = op_a + 32'h1111;
      check("R11 hold result", result, 32'hA000_000A);
      check("R11 hold valid", {31'd0, out_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wrap();
    t_ssat();
    t_usat();
    t_lane_add();
    t_cmp();
    t_logic();
    t_shift();
    t_undef();
    t_stream();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule